// File: doc/BRIEF.md
# Flash Read-Mode and Suspend Controller

This block keeps track of the read mode of a flash-style memory. From that mode it picks the source the data bus returns on every read. The three sources are the memory array, the status word and the identification data.

Its inputs come from three places:
- The write qualifier supplies qualified write strobes carrying a command byte.
- The command-sequence decoder supplies pulses that say a program or erase operation, or identification mode, has been accepted.
- The embedded program/erase engine supplies completion and timeout-error pulses.

A per-sector vector marks which sectors are held in erase suspend. The read path supplies the sector index of the current read.

After reset the block reads the array with no command needed. A stray or unexpected write leaves it reading the array. While an erase is running it can be suspended. During suspend, reads of suspended sectors return status and all other reads return array data. A program operation may run inside the suspend. When it completes, the block goes back to suspend reads. Two modes can only be left with the reset command: the error mode entered on a timeout, and identification mode. A supply-lockout input forces array reads and blocks all command handling while it is held.

Top module: `flrm_ctrl`

## Requirements
- R1: After reset `mode` is 0 (array) and `rd_sel` is 0 (array data). The mode codes are 0 array, 1 erase busy, 2 program busy, 3 erase suspended, 4 program within suspend, 5 error and 6 identification. The `rd_sel` codes are 0 array, 1 status and 2 identification.
- R2: In array mode, `op_start` moves the block to mode 1 when `op_erase` is 1 and to mode 2 otherwise. Otherwise, `as_enter` moves it to mode 6. Any write, including an unrecognised byte, leaves it in mode 0.
- R3: Modes 1, 2 and 4 select status. When `eng_done` is seen, modes 1 and 2 return to 0 and mode 4 returns to 3.
- R4: A write of 0xB0 in mode 1 moves the block to mode 3 on the next cycle. A write of 0xB0 in mode 2 has no effect.
- R5: In mode 3, `rd_sel` is 1 when `sect_susp[rd_sector]` is 1 and 0 otherwise. This is combinational in the read inputs.
- R6: A write of 0x30 in mode 3 moves the block to mode 1.
- R7: In mode 3, `op_start` with `op_erase`=0 moves the block to mode 4. `op_start` with `op_erase`=1 is ignored, and so are `eng_done` and `eng_err`.
- R8: `eng_err` in mode 1, 2 or 4 moves the block to mode 5, which selects status. Only a write of 0xF0 leaves mode 5, going to mode 0. Every other input is ignored there.
- R9: Mode 6 selects identification data. Only a write of 0xF0 leaves it, going to mode 0.
- R10: While `lockout` is 1 the block enters mode 0 on the next edge. All writes, start and engine pulses are ignored for as long as it is held.
- R11: When inputs arrive in the same cycle, priority runs from highest to lowest: `lockout`, then `eng_err`, then `eng_done`, then commands. In mode 3, 0x30 wins over `op_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lockout | input | 1 | Supply lockout; forces array mode and blocks commands |
| wr_valid | input | 1 | Qualified write strobe |
| wr_data | input | DW | Command byte of the write |
| op_start | input | 1 | Program or erase accepted by the sequence decoder |
| op_erase | input | 1 | With `op_start`: 1 erase, 0 program |
| as_enter | input | 1 | Identification-mode entry accepted |
| eng_done | input | 1 | Embedded operation completed |
| eng_err | input | 1 | Embedded operation timed out |
| sect_susp | input | NSECT | Per-sector erase-suspend flags |
| rd_sector | input | $clog2(NSECT) | Sector index of the current read |
| rd_sel | output | 2 | Read data source |
| mode | output | 3 | Current mode code |

## Verification
The assertions assume three things about the inputs:
- All inputs carry known values once reset is released.
- `rd_sector` stays below NSECT.
- The engine pulses last a single cycle.

The bench drives a full-width sector index at the default power-of-two sector count, so every index it produces is legal. Engine and command pulses are cleared after every cycle. The random phase draws command bytes only from the recognised codes plus two unrecognised ones. This keeps every mode's exits reachable without producing inputs outside those assumptions.

// File: rtl/flrm_pkg.sv
package flrm_pkg;
    typedef enum logic [2:0] {
        M_ARRAY   = 3'd0,
        M_BUSY_ER = 3'd1,
        M_BUSY_PG = 3'd2,
        M_SUSP    = 3'd3,
        M_SUSP_PG = 3'd4,
        M_ERROR   = 3'd5,
        M_IDENT   = 3'd6
    } mode_e;

    typedef enum logic [1:0] {
        SEL_ARRAY  = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_IDENT  = 2'd2
    } sel_e;

    typedef struct packed {
        logic reset;
        logic suspend;
        logic resume;
    } cmd_t;

    typedef struct packed {
        mode_e mode;
    } ctl_t;
endpackage

// File: rtl/flrm_cmd_dec.sv
module flrm_cmd_dec
    import flrm_pkg::*;
#(
    parameter int DW = 8,
    parameter logic [DW-1:0] CODE_RESET  = 8'hF0,
    parameter logic [DW-1:0] CODE_SUSP   = 8'hB0,
    parameter logic [DW-1:0] CODE_RESUME = 8'h30
) (
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          lockout,
    output cmd_t          cmd
);
    logic live;

    always_comb begin
        live        = wr_valid && !lockout;
        cmd.reset   = live && (wr_data == CODE_RESET);
        cmd.suspend = live && (wr_data == CODE_SUSP);
        cmd.resume  = live && (wr_data == CODE_RESUME);
    end
endmodule

// File: rtl/flrm_mode_fsm.sv
module flrm_mode_fsm
    import flrm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lockout,
    input  cmd_t  cmd,
    input  logic  op_start,
    input  logic  op_erase,
    input  logic  as_enter,
    input  logic  eng_done,
    input  logic  eng_err,
    output mode_e mode
);
    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (lockout) begin
            ctl_d.mode = M_ARRAY;
        end else begin
            unique case (ctl_q.mode)
                M_ARRAY: begin
                    if (op_start)      ctl_d.mode = op_erase ? M_BUSY_ER : M_BUSY_PG;
                    else if (as_enter) ctl_d.mode = M_IDENT;
                end
                M_BUSY_ER: begin
                    if (eng_err)          ctl_d.mode = M_ERROR;
                    else if (eng_done)    ctl_d.mode = M_ARRAY;
                    else if (cmd.suspend) ctl_d.mode = M_SUSP;
                end
                M_BUSY_PG: begin
                    if (eng_err)       ctl_d.mode = M_ERROR;
                    else if (eng_done) ctl_d.mode = M_ARRAY;
                end
                M_SUSP: begin
                    if (cmd.resume)                ctl_d.mode = M_BUSY_ER;
                    else if (op_start && !op_erase) ctl_d.mode = M_SUSP_PG;
                end
                M_SUSP_PG: begin
                    if (eng_err)       ctl_d.mode = M_ERROR;
                    else if (eng_done) ctl_d.mode = M_SUSP;
                end
                M_ERROR, M_IDENT: begin
                    if (cmd.reset) ctl_d.mode = M_ARRAY;
                end
                default: ctl_d.mode = M_ARRAY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{mode: M_ARRAY};
        else        ctl_q <= ctl_d;
    end

    assign mode = ctl_q.mode;
endmodule

// File: rtl/flrm_read_sel.sv
module flrm_read_sel
    import flrm_pkg::*;
#(
    parameter int NSECT = 16,
    localparam int SW = (NSECT > 1) ? $clog2(NSECT) : 1
) (
    input  mode_e             mode,
    input  logic [NSECT-1:0]  sect_susp,
    input  logic [SW-1:0]     rd_sector,
    output sel_e              sel
);
    logic [NSECT-1:0] hit;

    for (genvar s = 0; s < NSECT; s++) begin : g_hit
        assign hit[s] = sect_susp[s] && (rd_sector == SW'(s));
    end

    always_comb begin
        unique case (mode)
            M_ARRAY:                                sel = SEL_ARRAY;
            M_IDENT:                                sel = SEL_IDENT;
            M_SUSP:                                 sel = (|hit) ? SEL_STATUS : SEL_ARRAY;
            M_BUSY_ER, M_BUSY_PG, M_SUSP_PG, M_ERROR: sel = SEL_STATUS;
            default:                                sel = SEL_ARRAY;
        endcase
    end
endmodule

// File: rtl/flrm_ctrl.sv
module flrm_ctrl
    import flrm_pkg::*;
#(
    parameter int NSECT = 16,
    parameter int DW = 8,
    localparam int SW = (NSECT > 1) ? $clog2(NSECT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lockout,
    input  logic             wr_valid,
    input  logic [DW-1:0]    wr_data,
    input  logic             op_start,
    input  logic             op_erase,
    input  logic             as_enter,
    input  logic             eng_done,
    input  logic             eng_err,
    input  logic [NSECT-1:0] sect_susp,
    input  logic [SW-1:0]    rd_sector,
    output logic [1:0]       rd_sel,
    output logic [2:0]       mode
);
    cmd_t  cmd;
    mode_e cur_mode;
    sel_e  cur_sel;

    flrm_cmd_dec #(.DW(DW)) u_dec (
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .lockout  (lockout),
        .cmd      (cmd)
    );

    flrm_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lockout  (lockout),
        .cmd      (cmd),
        .op_start (op_start),
        .op_erase (op_erase),
        .as_enter (as_enter),
        .eng_done (eng_done),
        .eng_err  (eng_err),
        .mode     (cur_mode)
    );

    flrm_read_sel #(.NSECT(NSECT)) u_sel (
        .mode      (cur_mode),
        .sect_susp (sect_susp),
        .rd_sector (rd_sector),
        .sel       (cur_sel)
    );

    assign rd_sel = cur_sel;
    assign mode   = cur_mode;
endmodule

// File: rtl/flrm_ctrl_chk.sv
module flrm_ctrl_chk #(
    parameter int NSECT = 16,
    parameter int DW = 8,
    localparam int SW = (NSECT > 1) ? $clog2(NSECT) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lockout,
    input logic             wr_valid,
    input logic [DW-1:0]    wr_data,
    input logic             op_start,
    input logic             op_erase,
    input logic             as_enter,
    input logic             eng_done,
    input logic             eng_err,
    input logic [NSECT-1:0] sect_susp,
    input logic [SW-1:0]    rd_sector,
    input logic [1:0]       rd_sel,
    input logic [2:0]       mode
);
    logic wr_reset;
    assign wr_reset = wr_valid && (wr_data == DW'(8'hF0));

    a_r1_legal_mode: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 3'd7);

    a_r2_array_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && !op_start && !as_enter) |=> mode == 3'd0);

    a_r3_susp_return: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4 && eng_done && !eng_err && !lockout) |=> mode == 3'd3);

    a_r4_pg_no_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2 && !eng_done && !eng_err && !lockout) |=> mode == 3'd2);

    a_r5_susp_sector: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3) |-> rd_sel == (sect_susp[rd_sector] ? 2'd1 : 2'd0));

    a_r6_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && wr_valid && wr_data == DW'(8'h30) && !lockout) |=> mode == 3'd1);

    a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd5 && !wr_reset && !lockout) |=> mode == 3'd5);

    a_r9_ident_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd6 && !wr_reset && !lockout) |=> mode == 3'd6 && rd_sel == 2'd2);

    a_r10_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> mode == 3'd0);

    a_r11_err_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1 && eng_err && eng_done && !lockout) |=> mode == 3'd5);
endmodule

bind flrm_ctrl flrm_ctrl_chk #(.NSECT(NSECT), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lockout   (lockout),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .op_start  (op_start),
    .op_erase  (op_erase),
    .as_enter  (as_enter),
    .eng_done  (eng_done),
    .eng_err   (eng_err),
    .sect_susp (sect_susp),
    .rd_sector (rd_sector),
    .rd_sel    (rd_sel),
    .mode      (mode)
);

// File: tb/test_flrm_ctrl.sv
module test_flrm_ctrl;
    localparam int NSECT = 16;
    localparam int SW = $clog2(NSECT);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lockout = 1'b0, wr_valid = 1'b0, op_start = 1'b0, op_erase = 1'b0;
    logic as_enter = 1'b0, eng_done = 1'b0, eng_err = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [NSECT-1:0] sect_susp = '0;
    logic [SW-1:0] rd_sector = '0;
    logic [1:0] rd_sel;
    logic [2:0] mode;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int m_mode = 0;

    always #4 clk = ~clk;

    flrm_ctrl i_flrm_ctrl (
        .clk(clk), .rst_n(rst_n), .lockout(lockout), .wr_valid(wr_valid),
        .wr_data(wr_data), .op_start(op_start), .op_erase(op_erase),
        .as_enter(as_enter), .eng_done(eng_done), .eng_err(eng_err),
        .sect_susp(sect_susp), .rd_sector(rd_sector), .rd_sel(rd_sel), .mode(mode)
    );

    // Behavioural reference model of the mode codes listed in the requirements.
    function automatic int next_mode(int m);
        bit w_f0 = wr_valid && wr_data == 8'hF0;
        bit w_b0 = wr_valid && wr_data == 8'hB0;
        bit w_30 = wr_valid && wr_data == 8'h30;
        if (lockout) return 0;
        case (m)
            0: return op_start ? (op_erase ? 1 : 2) : (as_enter ? 6 : 0);
            1: return eng_err ? 5 : eng_done ? 0 : w_b0 ? 3 : 1;
            2: return eng_err ? 5 : eng_done ? 0 : 2;
            3: return w_30 ? 1 : (op_start && !op_erase) ? 4 : 3;
            4: return eng_err ? 5 : eng_done ? 3 : 4;
            5: return w_f0 ? 0 : 5;
            6: return w_f0 ? 0 : 6;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_sel(int m);
        if (m == 0) return 0;
        if (m == 6) return 2;
        if (m == 3) return sect_susp[rd_sector] ? 1 : 0;
        return 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_mode = 0;
        else        m_mode = next_mode(m_mode);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic clear_in();
        wr_valid = 0; op_start = 0; op_erase = 0; as_enter = 0;
        eng_done = 0; eng_err = 0; lockout = 0;
    endtask

    task automatic tick(string tag);
        #1;
        checks++;
        if (mode !== 3'(m_mode)) begin
            errors++;
            $display("FAIL %s mode: actual %0d expected %0d", tag, mode, m_mode);
        end
        checks++;
        if (rd_sel !== 2'(exp_sel(m_mode))) begin
            errors++;
            $display("FAIL %s rd_sel: actual %0d expected %0d", tag, rd_sel, exp_sel(m_mode));
        end
        @(negedge clk);
        clear_in();
    endtask

    task automatic wr(logic [7:0] d, string tag);
        wr_valid = 1; wr_data = d; tick(tag);
    endtask

    task automatic op(logic er, string tag);
        op_start = 1; op_erase = er; tick(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick("R1");                       // R1: reset state
        wr(8'h55, "R2"); tick("R2");      // R2: bad write stays array
        op(1'b1, "R2"); tick("R3");       // R3: erase busy shows status
        eng_done = 1; tick("R3"); tick("R3");
        as_enter = 1; tick("R9"); tick("R9");
        wr(8'h90, "R9"); wr(8'h30, "R9"); // R9: ident sticky
        wr(8'hF0, "R9"); tick("R9");
        op(1'b0, "R4"); wr(8'hB0, "R4"); tick("R4"); // R4: no suspend of program
        eng_done = 1; tick("R3");
        op(1'b1, "R4"); wr(8'hB0, "R4"); tick("R4");
        sect_susp = 16'h0005;
        for (int s = 0; s < 4; s++) begin // R5: per-sector selection
            rd_sector = SW'(s); tick("R5");
        end
        eng_done = 1; eng_err = 1; tick("R7"); // R7: engine ignored in suspend
        op(1'b1, "R7"); tick("R7");
        rd_sector = 4'd1; op(1'b0, "R7"); tick("R7");
        eng_done = 1; tick("R3"); tick("R3");
        wr_valid = 1; wr_data = 8'h30; op_start = 1; tick("R11"); // R11: resume wins
        tick("R6");                       // R6: resumed erase
        eng_err = 1; eng_done = 1; tick("R11"); tick("R8");
        wr(8'h30, "R8"); eng_done = 1; tick("R8"); op(1'b1, "R8");
        wr(8'hF0, "R8"); tick("R8");
        as_enter = 1; tick("R10");
        for (int k = 0; k < 3; k++) begin // R10: lockout blocks commands
            lockout = 1; op_start = 1; as_enter = 1; wr_valid = 1; wr_data = 8'hB0;
            tick("R10");
        end
        tick("R10");
        op(1'b1, "R10"); lockout = 1; eng_err = 1; tick("R11"); tick("R10");
        for (int i = 0; i < 4000; i++) begin // R11: mixed random traffic
            logic [2:0] pick = 3'($urandom_range(0, 4));
            lockout   = ($urandom_range(0, 19) == 0);
            eng_err   = ($urandom_range(0, 15) == 0);
            eng_done  = ($urandom_range(0, 5) == 0);
            op_start  = ($urandom_range(0, 4) == 0);
            op_erase  = 1'($urandom);
            as_enter  = ($urandom_range(0, 9) == 0);
            wr_valid  = 1'($urandom);
            wr_data   = (pick == 0) ? 8'hF0 : (pick == 1) ? 8'hB0 :
                        (pick == 2) ? 8'h30 : (pick == 3) ? 8'h55 : 8'h90;
            sect_susp = NSECT'($urandom);
            rd_sector = SW'($urandom);
            tick("R11");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule